// File: doc/BRIEF.md
# Multi-Channel Sample Voice Register Decoder

This block is the register front end of a 64-voice sample playback engine. Software writes 32-bit words into one of two address windows, each covering 32 voices at a stride of 128 bytes per voice. The block keeps the low half of every write to a decoded register slot. From these stored words it produces the parameters of one voice, chosen by an index input. The parameters are the sample start address, the loop flag, the sample format, the loop bounds, an integer sample rate converted from a floating-point pitch word, a remapped pan position and a gain taken from a square-law curve.

A config write with its key-execute bit set starts a sweep over every voice. The sweep issues one start/stop command per accepted handshake, in ascending voice order. Each command carries the voice index and a run flag, which is that voice's own stored key-on bit at the moment the command is presented. A busy output stays high until voice 63 has been accepted. Any stored word can be read back through a separate read address.

Top module: `voice_regfront`

## Requirements
- R1: The voice index of a write is the window-relative offset divided by 128, plus 32 when the window select is 1. The register slot is offset bits 6:2. Reading the same window and offset returns the stored 16-bit word.
- R2: Only data bits 15:0 are stored. Slots 0 to 11 (byte offsets 0x00 to 0x2C) are stored. A write to slot 12 or above changes nothing, and those slots read back as 0.
- R3: For the selected voice, start address bits 20:16 come from config (slot 0) bits 4:0, and the loop flag is config bit 9. The format output is 0 for 16-bit samples, 1 for 8-bit samples and 2 for ADPCM: config bits 8:7 of 0 give 0, 1 gives 1, and 2 or 3 give 2.
- R4: Start address bits 15:0 come from slot 1 (0x04). The loop start is slot 2 (0x08) and the loop end is slot 3 (0x0C).
- R5: The rate is computed from the pitch word (slot 6, 0x18), with m = bits 9:0 and e = bits 13:11. When bit 14 is 0, rate = (44100 << e) + ((44100·m) >> (10−e)).
- R6: When pitch bit 14 is 1, with k = 8 − e, rate = (44100 >> k) + ((44100·m) >> (10+k)). Pitch bit 10 has no effect.
- R7: The pan output takes p = bits 4:0 of slot 9 (0x24). It is 15 − p for p ≤ 15 and p for p ≥ 16.
- R8: The gain output is floor(v·(v+1)/256), where v = bits 7:0 of slot 10 (0x28).
- R9: A write to slot 0 with bit 15 set, while not busy, raises busy. From the next cycle the block presents commands for voices 0, 1, … 63 in turn. Each command's run flag is bit 14 of that voice's stored config when the command is presented.
- R10: A command is held unchanged while ready is low, and advances one voice per cycle in which valid and ready are both high. Busy and valid fall in the cycle after voice 63 is accepted.
- R11: A key-execute write during a sweep does not restart it, but its data is still stored and its key-on bit is used if that voice has not yet been commanded.
- R12: After reset, busy and valid are low and every slot reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 1 | Write window: 0 = voices 0-31, 1 = voices 32-63 |
| wr_addr | input | 12 | Byte offset inside the write window |
| wr_data | input | 32 | Write data (bits 15:0 used) |
| rd_win | input | 1 | Read-back window |
| rd_addr | input | 12 | Read-back byte offset |
| rd_data | output | 16 | Stored word at the read-back address |
| par_voice | input | 6 | Voice whose parameters are shown |
| par_start | output | 21 | Sample start address |
| par_loop_en | output | 1 | Loop enable |
| par_fmt | output | 2 | Sample format code |
| par_loop_start | output | 16 | Loop start |
| par_loop_end | output | 16 | Loop end |
| par_rate | output | 24 | Sample rate in samples per second |
| par_pan | output | 5 | Remapped pan |
| par_gain | output | 8 | Gain |
| cmd_valid | output | 1 | Start/stop command valid |
| cmd_ready | input | 1 | Command accepted by consumer |
| cmd_voice | output | 6 | Voice index of the command |
| cmd_run | output | 1 | 1 = start voice, 0 = stop voice |
| busy | output | 1 | Sweep in progress |

## Verification
The same slot is written in both windows at the same relative offset, which tells the window select apart from the voice field. Pitch words cover both exponent signs, both ends of the mantissa and bit 10 set, which exposes a wrong shift direction or a wrong shift amount. Pan and gain values sit on either side of the 15/16 fold and at the ends of the index range. Sweeps run once with ready held high and once with a periodic stall plus a mid-sweep key-execute write. These two runs separate ordering and hold errors from a sweep that restarts or reads stale key-on bits.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  typedef enum logic [1:0] {
    FMT_PCM16 = 2'd0,
    FMT_PCM8  = 2'd1,
    FMT_ADPCM = 2'd2
  } fmt_e;

  // register slot numbers (byte offset / 4) inside a voice stride
  localparam int unsigned SLOT_CFG    = 0;
  localparam int unsigned SLOT_SA_LO  = 1;
  localparam int unsigned SLOT_LSTART = 2;
  localparam int unsigned SLOT_LEND   = 3;
  localparam int unsigned SLOT_PITCH  = 6;
  localparam int unsigned SLOT_PAN    = 9;
  localparam int unsigned SLOT_GAIN   = 10;

  localparam int unsigned KEYEXEC_BIT = 15;
  localparam int unsigned KEYON_BIT   = 14;
endpackage

// File: rtl/vrf_store.sv
module vrf_store #(
  parameter int unsigned NUM_VOICES  = 64,
  parameter int unsigned VOICE_WORDS = 12,
  parameter int unsigned WORD_W      = 5,
  localparam int unsigned VID_W      = $clog2(NUM_VOICES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [VID_W-1:0]             wr_voice,
  input  logic [WORD_W-1:0]            wr_word,
  input  logic [15:0]                  wr_data,
  input  logic [VID_W-1:0]             rd_voice,
  input  logic [WORD_W-1:0]            rd_word,
  output logic [15:0]                  rd_data,
  input  logic [VID_W-1:0]             par_voice,
  output logic [VOICE_WORDS-1:0][15:0] par_words,
  input  logic [VID_W-1:0]             key_voice,
  output logic [15:0]                  key_cfg
);
  logic [VOICE_WORDS-1:0][15:0] mem_q [NUM_VOICES];
  logic [VOICE_WORDS-1:0]       we [NUM_VOICES];

  // write enable decode
  always_comb begin
    for (int v = 0; v < NUM_VOICES; v++) begin
      for (int w = 0; w < VOICE_WORDS; w++) begin
        we[v][w] = wr_en && (wr_voice == VID_W'(v)) && (wr_word == WORD_W'(w));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VOICES; v++) mem_q[v] <= '0;
    end else begin
      for (int v = 0; v < NUM_VOICES; v++) begin
        for (int w = 0; w < VOICE_WORDS; w++) begin
          if (we[v][w]) mem_q[v][w] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < VOICE_WORDS; w++) begin
      if (rd_word == WORD_W'(w)) rd_data = mem_q[rd_voice][w];
    end
    par_words = mem_q[par_voice];
    key_cfg   = mem_q[key_voice][0];
  end
endmodule

// File: rtl/vrf_pitch.sv
module vrf_pitch #(
  parameter int unsigned BASE_RATE = 44100,
  parameter int unsigned RATE_W    = 24
) (
  input  logic [15:0]       pitch,
  output logic [RATE_W-1:0] rate
);
  localparam int unsigned CALC_W = 40;

  logic [9:0]        mant;
  logic [2:0]        expo;
  logic              neg;
  logic [4:0]        sh_base;
  logic [4:0]        sh_frac;
  logic [CALC_W-1:0] base;
  logic [CALC_W-1:0] prod;
  logic [CALC_W-1:0] sum;
  logic              unused_pitch;

  assign mant = pitch[9:0];
  assign expo = pitch[13:11];
  assign neg  = pitch[14];
  assign unused_pitch = pitch[15] ^ pitch[10];

  always_comb begin
    base = CALC_W'(BASE_RATE);
    prod = base * CALC_W'(mant);
    if (neg) begin
      sh_base = 5'd8 - {2'b00, expo};
      sh_frac = 5'd10 + sh_base;
      sum     = (base >> sh_base) + (prod >> sh_frac);
    end else begin
      sh_base = {2'b00, expo};
      sh_frac = 5'd10 - sh_base;
      sum     = (base << sh_base) + (prod >> sh_frac);
    end
    rate = sum[RATE_W-1:0];
  end
endmodule

// File: rtl/vrf_sweep.sv
module vrf_sweep #(
  parameter int unsigned NUM_VOICES = 64,
  localparam int unsigned VID_W     = $clog2(NUM_VOICES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             ready,
  output logic             busy,
  output logic [VID_W-1:0] idx
);
  localparam logic [VID_W-1:0] LAST = VID_W'(NUM_VOICES - 1);

  logic             busy_q, busy_d;
  logic [VID_W-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (!busy_q) begin
      if (launch) begin
        busy_d = 1'b1;
        idx_d  = '0;
      end
    end else if (ready) begin
      if (idx_q == LAST) busy_d = 1'b0;
      else               idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
endmodule

// File: rtl/voice_regfront.sv
module voice_regfront #(
  parameter int unsigned WIN_VOICES  = 32,
  parameter int unsigned VOICE_WORDS = 12,
  parameter int unsigned BASE_RATE   = 44100,
  parameter int unsigned RATE_W      = 24,
  localparam int unsigned NUM_VOICES = 2 * WIN_VOICES,
  localparam int unsigned VID_W      = $clog2(NUM_VOICES),
  localparam int unsigned STRIDE_SH  = 7,
  localparam int unsigned ADDR_W     = $clog2(WIN_VOICES) + STRIDE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_win,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_win,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  input  logic [VID_W-1:0]  par_voice,
  output logic [20:0]       par_start,
  output logic              par_loop_en,
  output logic [1:0]        par_fmt,
  output logic [15:0]       par_loop_start,
  output logic [15:0]       par_loop_end,
  output logic [RATE_W-1:0] par_rate,
  output logic [4:0]        par_pan,
  output logic [7:0]        par_gain,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [VID_W-1:0]  cmd_voice,
  output logic              cmd_run,
  output logic              busy
);
  import vrf_pkg::*;

  localparam int unsigned WORD_W = STRIDE_SH - 2;

  logic [VID_W-1:0]             wr_voice, rd_voice, sweep_idx;
  logic [WORD_W-1:0]            wr_word, rd_word;
  logic [VOICE_WORDS-1:0][15:0] par_words;
  logic [15:0]                  key_cfg;
  logic                         launch, sweep_busy;
  logic [15:0]                  cfg_w, pan_w, gain_w;
  logic [4:0]                   pan_raw;
  logic [15:0]                  gain_sq;
  fmt_e                         fmt;
  logic                         unused_bits;

  assign wr_voice = {wr_win, wr_addr[ADDR_W-1:STRIDE_SH]};
  assign rd_voice = {rd_win, rd_addr[ADDR_W-1:STRIDE_SH]};
  assign wr_word  = wr_addr[STRIDE_SH-1:2];
  assign rd_word  = rd_addr[STRIDE_SH-1:2];

  vrf_store #(
    .NUM_VOICES (NUM_VOICES),
    .VOICE_WORDS(VOICE_WORDS),
    .WORD_W     (WORD_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_voice (wr_voice),
    .wr_word  (wr_word),
    .wr_data  (wr_data[15:0]),
    .rd_voice (rd_voice),
    .rd_word  (rd_word),
    .rd_data  (rd_data),
    .par_voice(par_voice),
    .par_words(par_words),
    .key_voice(sweep_idx),
    .key_cfg  (key_cfg)
  );

  assign launch = wr_en && (wr_word == WORD_W'(SLOT_CFG)) && wr_data[KEYEXEC_BIT];

  vrf_sweep #(.NUM_VOICES(NUM_VOICES)) u_sweep (
    .clk   (clk),
    .rst_n (rst_n),
    .launch(launch),
    .ready (cmd_ready),
    .busy  (sweep_busy),
    .idx   (sweep_idx)
  );

  assign busy      = sweep_busy;
  assign cmd_valid = sweep_busy;
  assign cmd_voice = sweep_idx;
  assign cmd_run   = key_cfg[KEYON_BIT];

  vrf_pitch #(.BASE_RATE(BASE_RATE), .RATE_W(RATE_W)) u_pitch (
    .pitch(par_words[SLOT_PITCH]),
    .rate (par_rate)
  );

  assign cfg_w  = par_words[SLOT_CFG];
  assign pan_w  = par_words[SLOT_PAN];
  assign gain_w = par_words[SLOT_GAIN];

  always_comb begin
    unique case (cfg_w[8:7])
      2'd0:    fmt = FMT_PCM16;
      2'd1:    fmt = FMT_PCM8;
      default: fmt = FMT_ADPCM;
    endcase
  end

  assign par_fmt        = fmt;
  assign par_start      = {cfg_w[4:0], par_words[SLOT_SA_LO]};
  assign par_loop_en    = cfg_w[9];
  assign par_loop_start = par_words[SLOT_LSTART];
  assign par_loop_end   = par_words[SLOT_LEND];

  assign pan_raw = pan_w[4:0];
  assign par_pan = pan_raw[4] ? pan_raw : (5'd15 - pan_raw);

  assign gain_sq  = {8'd0, gain_w[7:0]} * ({8'd0, gain_w[7:0]} + 16'd1);
  assign par_gain = gain_sq[15:8];

  assign unused_bits = ^{wr_data[31:16], wr_addr[1:0], rd_addr[1:0], par_words,
                         key_cfg, gain_sq[7:0]};
endmodule

// File: rtl/voice_regfront_chk.sv
module voice_regfront_chk #(
  parameter int unsigned NUM_VOICES = 64,
  parameter int unsigned ADDR_W     = 12,
  localparam int unsigned VID_W     = $clog2(NUM_VOICES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              key_bit,
  input logic              busy,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [VID_W-1:0]  cmd_voice
);
  localparam logic [VID_W-1:0] LAST = VID_W'(NUM_VOICES - 1);

  logic key_wr;
  assign key_wr = wr_en && (wr_addr[6:2] == 5'd0) && key_bit;

  p_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && !busy |=> busy && cmd_valid && (cmd_voice == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_voice));

  // also covers R11: a key write mid-sweep must not pull the index back
  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_voice != LAST) |=> cmd_valid && (cmd_voice == $past(cmd_voice) + 1'b1));

  p_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_voice == LAST) |=> !busy && !cmd_valid);
endmodule

bind voice_regfront voice_regfront_chk #(
  .NUM_VOICES(NUM_VOICES),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .key_bit  (wr_data[15]),
  .busy     (busy),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_voice(cmd_voice)
);

// File: tb/voice_regfront_tb.sv
`timescale 1ns/1ps
module voice_regfront_tb;
  localparam int NV = 64;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_win = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_win = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic [5:0]    par_voice = '0;
  logic [20:0]   par_start;
  logic          par_loop_en;
  logic [1:0]    par_fmt;
  logic [15:0]   par_loop_start, par_loop_end;
  logic [23:0]   par_rate;
  logic [4:0]    par_pan;
  logic [7:0]    par_gain;
  logic          cmd_valid, cmd_ready = 1'b0, cmd_run, busy;
  logic [5:0]    cmd_voice;

  int total = 0, bad = 0;
  logic [15:0] cfg_sh [NV];

  always #2.5 clk = ~clk;

  voice_regfront u_dut (.*);

  task automatic check(string req, longint act, longint exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int voice, int ofs, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_win = (voice >= 32);
    wr_addr = AW'((voice % 32) * 128 + ofs); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (ofs == 0) cfg_sh[voice] = data[15:0];
  endtask

  task automatic rd(int voice, int ofs, output logic [15:0] val);
    rd_win = (voice >= 32); rd_addr = AW'((voice % 32) * 128 + ofs);
    #1 val = rd_data;
  endtask

  function automatic longint exp_rate(logic [15:0] p);
    longint m = p[9:0], e = p[13:11], k;
    if (!p[14]) return (longint'(44100) << e) + ((44100 * m) >> (10 - e));
    k = 8 - e;
    return (longint'(44100) >> k) + ((44100 * m) >> (10 + k));
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    check("R12", busy, 0, "busy after reset");
    check("R12", cmd_valid, 0, "valid after reset");
    rd(40, 8, v); check("R12", v, 0, "readback after reset");
  endtask

  task automatic t_windows();
    logic [15:0] v;
    wr(5, 4, 32'hDEAD_1234);
    wr(37, 4, 32'h0000_ABCD);
    rd(5, 4, v);  check("R1", v, 16'h1234, "window0 voice5 slot1");
    rd(37, 4, v); check("R1", v, 16'hABCD, "window1 voice37 slot1");
    wr(6, 8'h30, 32'h5555);
    rd(6, 8'h30, v); check("R2", v, 0, "slot 12 not stored");
    wr(6, 8'h2C, 32'hFFFF_7777);
    rd(6, 8'h2C, v); check("R2", v, 16'h7777, "slot 11 low half");
  endtask

  task automatic t_config();
    logic [15:0] cfgs [4] = '{16'h0213, 16'h0080, 16'h0105, 16'h039F};
    logic [1:0]  fexp [4] = '{2'd0, 2'd1, 2'd2, 2'd2};
    wr(5, 8, 32'h0000_1111);
    wr(5, 12, 32'hF000_2222);
    par_voice = 6'd5;
    foreach (cfgs[i]) begin
      wr(5, 0, {16'h0, cfgs[i]});
      #1;
      check("R3", par_fmt, fexp[i], "format code");
      check("R3", par_loop_en, cfgs[i][9], "loop flag");
      check("R4", par_start, {cfgs[i][4:0], 16'h1234}, "start address");
    end
    check("R4", par_loop_start, 16'h1111, "loop start");
    check("R4", par_loop_end, 16'h2222, "loop end");
  endtask

  task automatic t_pitch();
    logic [15:0] ps [6] = '{16'h0000, 16'h1200, 16'h3BFF, 16'h7C00, 16'h43FF, 16'h2655};
    par_voice = 6'd44;
    foreach (ps[i]) begin
      wr(44, 8'h18, {16'h0, ps[i]});
      #1;
      check(ps[i][14] ? "R6" : "R5", par_rate, exp_rate(ps[i]), "rate");
    end
    wr(44, 8'h18, 32'h0000_4C10);
    #1 check("R6", par_rate, exp_rate(16'h4810), "bit10 ignored");
  endtask

  task automatic t_pan_gain();
    int pans [6] = '{0, 7, 15, 16, 31, 32'hE9};
    int gs [5] = '{0, 64, 128, 200, 255};
    par_voice = 6'd63;
    foreach (pans[i]) begin
      int p = pans[i] & 31;
      wr(63, 8'h24, pans[i]);
      #1 check("R7", par_pan, (p <= 15) ? 15 - p : p, "pan map");
    end
    foreach (gs[i]) begin
      wr(63, 8'h28, 32'h0000_AB00 | gs[i]);
      #1 check("R8", par_gain, (gs[i] * (gs[i] + 1)) >> 8, "gain curve");
    end
  endtask

  task automatic sweep(int trig, logic [15:0] cfg, bit stall, int inj_cyc, int inj_voice);
    int e = 0, cyc = 0;
    bit rdy;
    wr(trig, 0, {16'h0, cfg});
    while (e < NV && cyc < 1000) begin
      if (!cmd_valid) begin
        check("R9", cmd_valid, 1, "valid during sweep");
        break;
      end
      check(stall ? "R10" : "R9", cmd_voice, e, "command order");
      check("R9", cmd_run, cfg_sh[e][14], "run flag");
      rdy = stall ? (cyc % 3 != 2) : 1'b1;
      cmd_ready = rdy;
      if (cyc == inj_cyc) begin
        wr_en = 1'b1; wr_win = (inj_voice >= 32);
        wr_addr = AW'((inj_voice % 32) * 128); wr_data = 32'h0000_8000;
        cfg_sh[inj_voice] = 16'h8000;
      end else wr_en = 1'b0;
      if (rdy) e++;
      @(negedge clk);
      cyc++;
    end
    cmd_ready = 1'b0; wr_en = 1'b0;
    check("R10", e, NV, "all voices commanded");
    check("R10", busy, 0, "busy clears after last");
    check("R10", cmd_valid, 0, "valid clears after last");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R9: act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < NV; i++) cfg_sh[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_windows();
    t_config();
    t_pitch();
    t_pan_gain();
    for (int i = 0; i < NV; i += 5) wr(i, 0, 32'h0000_4000);
    sweep(10, 16'hC000, 1'b0, -1, 0);
    sweep(33, 16'hC001, 1'b1, 20, 50);
    rd(50, 0, v); check("R11", v, 16'h8000, "mid-sweep write stored");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule